// File: doc/BRIEF.md
# Multi-Standard Turbo Constituent Encoder

This block is the recursive systematic convolutional half of a turbo encoder. It has an eight-state trellis and serves four radio profiles, chosen by a two-bit mode input. Three profiles are binary. They take one bit per accepted beat, leave the register in state 0 with a three-step zero tail, and emit one parity bit (rate 1/3) or two parity bits (rate 1/5). The fourth profile is duo-binary. It takes a bit pair (A, B) per beat and emits a Y and a W parity bit. It closes the block by tail biting, so the trellis starts and ends in the same state.

Input arrives as a valid/ready stream. Start-of-block and end-of-block flags frame each block. Binary beats are coded as they arrive, and their outputs appear one cycle after acceptance. Duo-binary pairs are stored while a first pass runs from state 0. At end of block, the final state and the block length mod 7 together give the circulation state. A second pass from that state then replays the stored pairs to the output. The output stream has no backpressure.

The register state is three bits. Bit 0 is the one-step delay, bit 1 the two-step delay and bit 2 the three-step delay.

The controller has six states:
- S_IDLE waits for a start-of-block beat.
- S_BIN_RUN codes binary beats.
- S_BIN_TAIL emits the three tail steps.
- S_DUO_LOAD stores pairs and runs the first pass.
- S_DUO_EMIT runs the second pass.
- S_DUO_FAIL is reserved; the controller never enters it.

The transitions are:
- From S_IDLE, an accepted start beat goes to S_BIN_RUN in binary modes, or to S_DUO_LOAD in duo-binary mode.
- If that start beat also ends the block, the controller goes straight to S_BIN_TAIL in binary modes. In duo-binary mode it goes to S_DUO_EMIT, or back to S_IDLE on error.
- From S_BIN_RUN, an end-of-block beat goes to S_BIN_TAIL.
- S_BIN_TAIL returns to S_IDLE after its third step.
- From S_DUO_LOAD, an end-of-block beat goes to S_DUO_EMIT, or to S_IDLE on error.
- S_DUO_EMIT returns to S_IDLE after the last stored pair.

Top module: `tce_encoder`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: cfg_mode is sampled on the accepted start-of-block beat: 0 and 1 select binary rate 1/3, 2 selects binary rate 1/5, and 3 selects duo-binary. Changes to cfg_mode during a block have no effect on that block's output.
- R3: In binary modes, each accepted bit x is coded as follows, with feedback f = s1 ^ s2 and w = x ^ f:
  - One cycle later, the block emits out_sys[0] = x, out_sys[1] = 0, and out_par[0] = w ^ s0 ^ s2 (parity polynomial 1+D+D^3).
  - In the rate-1/3 modes, out_par[1] = 0.
  - The next state is {s1, s0, w}.
- R4: In mode 2, out_par[1] = w ^ s0 ^ s1 ^ s2 (polynomial 1+D+D^2+D^3).
- R5: After a binary end-of-block beat, the block drives in_ready low and emits three beats with out_tail = 1. For each tail beat:
  - The input is forced to f, and out_sys[0] = f.
  - The parity bits follow R3/R4.
  - The register ends in state 0.
  - out_last = 1 on the third tail beat only.
- R6: In mode 3, in_data[0] is A and in_data[1] is B. The step uses w = A ^ B ^ s0 ^ s2 and the following rules:
  - The next state is {s1 ^ B, s0 ^ B, w}.
  - out_par[0] = w ^ s1 ^ s2 (Y).
  - out_par[1] = w ^ s2 (W).
  - out_sys = {B, A}.
- R7: A duo-binary block of N pairs is emitted only after end of block, with in_ready low during emission. The output is the encoding from the unique start state c whose N-step end state is c again. out_last = 1 on the final pair.
- R8: A duo-binary block with N mod 7 = 0 produces exactly one beat with out_err = 1 and out_last = 1, and no data beats.
- R9: A duo-binary block longer than MAX_PAIRS (default 64) produces the same single error beat.
- R10: In S_IDLE, beats without the start flag are accepted and dropped, and they produce no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 2 | Profile select, sampled at start of block |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Encoder can accept a beat |
| in_data | input | 2 | Bit 0: binary bit or A; bit 1: B |
| in_sob | input | 1 | First beat of a block |
| in_eob | input | 1 | Last beat of a block |
| out_valid | output | 1 | Output beat valid |
| out_sys | output | 2 | Systematic symbol(s) |
| out_par | output | 2 | Parity bits |
| out_tail | output | 1 | Beat is a zero-tail step |
| out_last | output | 1 | Final beat of the block's output |
| out_err | output | 1 | Block rejected (duo-binary length) |

## Verification
The hardest case to reach is the circulation-state selection. It only shows when a block's pass-one end state is nonzero and the length takes several different residues mod 7. The stimulus table therefore holds duo-binary blocks of lengths 8, 12, 20 and 64 (residues 1, 5, 6, 1) with dense bit patterns. For each block, the bench finds the expected start state by trying all eight candidates against its own reference. Rejected lengths come from a 7-pair block and a 65-pair block. A mid-block change of cfg_mode, idle beats without a start flag, and stalls in the input stream are driven as directed cases.

// File: rtl/tce_pkg.sv
package tce_pkg;

    typedef enum logic [1:0] {
        MODE_BIN3_A = 2'd0,
        MODE_BIN3_B = 2'd1,
        MODE_BIN5   = 2'd2,
        MODE_DUO    = 2'd3
    } tce_mode_e;

    typedef enum logic [2:0] {
        S_IDLE     = 3'd0,
        S_BIN_RUN  = 3'd1,
        S_BIN_TAIL = 3'd2,
        S_DUO_LOAD = 3'd3,
        S_DUO_EMIT = 3'd4,
        S_DUO_FAIL = 3'd5
    } tce_state_e;

    localparam int TRELLIS_BITS = 3;
    localparam int TAIL_STEPS   = 3;

endpackage

// File: rtl/tce_rsc_step.sv
module tce_rsc_step
    import tce_pkg::*;
(
    input  logic                    duo,
    input  logic                    flush,
    input  logic [TRELLIS_BITS-1:0] st,
    input  logic                    a,
    input  logic                    b,
    output logic [TRELLIS_BITS-1:0] nxt,
    output logic                    sym,
    output logic                    p0,
    output logic                    p1
);
    logic fb_bin;
    logic u_bin;
    logic w_bin;
    logic w_duo;

    always_comb begin
        fb_bin = st[1] ^ st[2];
        u_bin  = flush ? fb_bin : a;
        w_bin  = u_bin ^ fb_bin;
        w_duo  = a ^ b ^ st[0] ^ st[2];
        if (duo) begin
            nxt = {st[1] ^ b, st[0] ^ b, w_duo};
            sym = a;
            p0  = w_duo ^ st[1] ^ st[2];
            p1  = w_duo ^ st[2];
        end else begin
            nxt = {st[1], st[0], w_bin};
            sym = u_bin;
            p0  = w_bin ^ st[0] ^ st[2];
            p1  = w_bin ^ st[0] ^ st[1] ^ st[2];
        end
    end
endmodule

// File: rtl/tce_circ_solve.sv
module tce_circ_solve
    import tce_pkg::*;
(
    input  logic [TRELLIS_BITS-1:0] end_state,
    input  logic [2:0]              len_mod7,
    output logic [TRELLIS_BITS-1:0] circ
);
    always_comb begin
        circ = '0;
        for (int c = 0; c < 8; c++) begin
            logic [2:0] t;
            t = 3'(c);
            for (int k = 1; k < 7; k++) begin
                if (3'(k) <= len_mod7) begin
                    t = {t[1], t[0], t[0] ^ t[2]};
                end
            end
            if ((t ^ 3'(c)) == end_state) begin
                circ = 3'(c);
            end
        end
    end
endmodule

// File: rtl/tce_pair_buf.sv
module tce_pair_buf #(
    parameter int DEPTH = 64,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [1:0]    wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [1:0]    rd_data
);
    logic [1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/tce_encoder.sv
module tce_encoder
    import tce_pkg::*;
#(
    parameter int MAX_PAIRS = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] cfg_mode,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic [1:0] in_data,
    input  logic       in_sob,
    input  logic       in_eob,
    output logic       out_valid,
    output logic [1:0] out_sys,
    output logic [1:0] out_par,
    output logic       out_tail,
    output logic       out_last,
    output logic       out_err
);
    localparam int CW = $clog2(MAX_PAIRS + 1);
    localparam int AW = (MAX_PAIRS > 1) ? $clog2(MAX_PAIRS) : 1;

    tce_state_e state_q, state_d;
    tce_mode_e  mode_q, mode_cur;
    logic [TRELLIS_BITS-1:0] st_q, core_st, core_nxt, circ, circ_q;
    logic [CW-1:0] cnt_q, idx_q, cnt_base, cnt_nx;
    logic [2:0]    mod_q, mod_base, mod_nx;
    logic          ovf_q, ovf_base, ovf_nx;
    logic [1:0]    tcnt_q;
    logic          fire, take, duo_cur, store, duo_bad, emitting, emit_done;
    logic          core_a, core_b, core_sym, core_p0, core_p1;
    logic [1:0]    rd_pair;

    assign in_ready  = (state_q == S_IDLE) || (state_q == S_BIN_RUN) || (state_q == S_DUO_LOAD);
    assign fire      = in_valid && in_ready;
    assign take      = fire && ((state_q != S_IDLE) || in_sob);
    assign mode_cur  = (state_q == S_IDLE) ? tce_mode_e'(cfg_mode) : mode_q;
    assign duo_cur   = (mode_cur == MODE_DUO);
    assign emitting  = (state_q == S_DUO_EMIT);
    assign emit_done = emitting && (idx_q == cnt_q - CW'(1));

    assign cnt_base = (state_q == S_IDLE) ? '0 : cnt_q;
    assign mod_base = (state_q == S_IDLE) ? '0 : mod_q;
    assign ovf_base = (state_q == S_IDLE) ? 1'b0 : ovf_q;
    assign store    = take && duo_cur && (cnt_base < CW'(MAX_PAIRS));
    assign cnt_nx   = store ? cnt_base + CW'(1) : cnt_base;
    assign mod_nx   = (mod_base == 3'd6) ? 3'd0 : mod_base + 3'd1;
    assign ovf_nx   = ovf_base || (take && duo_cur && (cnt_base == CW'(MAX_PAIRS)));
    assign duo_bad  = ovf_nx || (mod_nx == 3'd0);

    assign core_st = (state_q == S_IDLE) ? '0 : st_q;
    assign core_a  = emitting ? rd_pair[0] : in_data[0];
    assign core_b  = emitting ? rd_pair[1] : in_data[1];

    tce_rsc_step u_step (
        .duo   (duo_cur),
        .flush (state_q == S_BIN_TAIL),
        .st    (core_st),
        .a     (core_a),
        .b     (core_b),
        .nxt   (core_nxt),
        .sym   (core_sym),
        .p0    (core_p0),
        .p1    (core_p1)
    );

    tce_circ_solve u_circ (
        .end_state (core_nxt),
        .len_mod7  (mod_nx),
        .circ      (circ)
    );

    tce_pair_buf #(.DEPTH(MAX_PAIRS)) u_buf (
        .clk     (clk),
        .wr_en   (store),
        .wr_addr (cnt_base[AW-1:0]),
        .wr_data (in_data),
        .rd_addr (idx_q[AW-1:0]),
        .rd_data (rd_pair)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (take) begin
                    if (duo_cur) state_d = !in_eob ? S_DUO_LOAD : (duo_bad ? S_IDLE : S_DUO_EMIT);
                    else         state_d = in_eob ? S_BIN_TAIL : S_BIN_RUN;
                end
            end
            S_BIN_RUN:  if (take && in_eob) state_d = S_BIN_TAIL;
            S_BIN_TAIL: if (tcnt_q == 2'(TAIL_STEPS - 1)) state_d = S_IDLE;
            S_DUO_LOAD: if (take && in_eob) state_d = duo_bad ? S_IDLE : S_DUO_EMIT;
            S_DUO_EMIT: if (emit_done) state_d = S_IDLE;
            S_DUO_FAIL: state_d = S_IDLE;
            default:    state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // trellis, counters and buffer bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MODE_BIN3_A;
            st_q   <= '0;
            circ_q <= '0;
            cnt_q  <= '0;
            mod_q  <= '0;
            ovf_q  <= 1'b0;
            idx_q  <= '0;
            tcnt_q <= '0;
        end else begin
            if (state_q == S_IDLE && take) mode_q <= mode_cur;
            if (take && duo_cur) begin
                cnt_q <= cnt_nx;
                mod_q <= mod_nx;
                ovf_q <= ovf_nx;
            end
            if (state_d == S_DUO_EMIT && !emitting) begin
                st_q   <= circ;
                circ_q <= circ;
                idx_q  <= '0;
            end else if (take || state_q == S_BIN_TAIL || emitting) begin
                st_q <= core_nxt;
                if (emitting) idx_q <= idx_q + CW'(1);
            end
            if (state_q == S_BIN_TAIL) tcnt_q <= tcnt_q + 2'd1;
            else                       tcnt_q <= '0;
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_sys   <= '0;
            out_par   <= '0;
            out_tail  <= 1'b0;
            out_last  <= 1'b0;
            out_err   <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            out_sys   <= '0;
            out_par   <= '0;
            out_tail  <= 1'b0;
            out_last  <= 1'b0;
            out_err   <= 1'b0;
            if (take && !duo_cur) begin
                out_valid <= 1'b1;
                out_sys   <= {1'b0, core_sym};
                out_par   <= {(mode_cur == MODE_BIN5) & core_p1, core_p0};
            end else if (state_q == S_BIN_TAIL) begin
                out_valid <= 1'b1;
                out_sys   <= {1'b0, core_sym};
                out_par   <= {(mode_q == MODE_BIN5) & core_p1, core_p0};
                out_tail  <= 1'b1;
                out_last  <= (tcnt_q == 2'(TAIL_STEPS - 1));
            end else if (take && duo_cur && in_eob && duo_bad) begin
                out_valid <= 1'b1;
                out_err   <= 1'b1;
                out_last  <= 1'b1;
            end else if (emitting) begin
                out_valid <= 1'b1;
                out_sys   <= rd_pair;
                out_par   <= {core_p1, core_p0};
                out_last  <= emit_done;
            end
        end
    end

    assert_mode_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mode_q) |-> $past(state_q) == S_IDLE);

    assert_bin_sys_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !duo_cur) |=> (out_valid && !out_tail && out_sys[0] == $past(in_data[0])));

    assert_rate5_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && mode_q == MODE_BIN5) |-> ((out_par[0] ^ out_par[1]) == $past(core_st[1])));

    assert_tail_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_tail && !out_last) |=> (out_valid && out_tail));

    assert_tail_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_tail && out_last) |-> (st_q == '0));

    assert_circular_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_last && !out_err && !out_tail && mode_q == MODE_DUO) |-> (st_q == circ_q));

    assert_err_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_err |=> !out_valid);
endmodule

// File: tb/tce_encoder_tb.sv
module tce_encoder_tb;
    localparam int CLK_PERIOD = 10;
    localparam int MAXP = 64;
    localparam int NV = 10;

    localparam logic [1:0] T_MODE [NV] = '{2'd0, 2'd1, 2'd2, 2'd2, 2'd3, 2'd3, 2'd3, 2'd3, 2'd0, 2'd3};
    localparam int         T_LEN  [NV] = '{5, 1, 9, 40, 8, 12, 20, 64, 64, 7};
    localparam logic [127:0] T_DATA [NV] = '{
        128'h0000_0000_0000_0000_0000_0000_0000_0017,
        128'h0000_0000_0000_0000_0000_0000_0000_0001,
        128'h0000_0000_0000_0000_0000_0000_0000_01B5,
        128'h0000_0000_0000_0000_0000_00C3_5A96_E1F2,
        128'h0000_0000_0000_0000_0000_0000_0000_B4E7,
        128'h0000_0000_0000_0000_0000_0000_00D2_9C3B,
        128'h0000_0000_0000_0000_0000_0007_A5F1_C36E,
        128'h9E37_79B9_7F4A_7C15_F39C_C060_5CED_C834,
        128'h0000_0000_0000_0000_A5A5_3C3C_0FF0_9669,
        128'h0000_0000_0000_0000_0000_0000_0000_2D4B};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] cfg_mode = 2'd0;
    logic in_valid = 1'b0, in_sob = 1'b0, in_eob = 1'b0;
    logic [1:0] in_data = 2'd0;
    logic in_ready, out_valid, out_tail, out_last, out_err;
    logic [1:0] out_sys, out_par;

    int n_checks = 0;
    int n_bad = 0;

    logic [6:0] cap [256];
    int cap_n = 0;
    logic [6:0] expv [256];
    int exp_n = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tce_encoder #(.MAX_PAIRS(MAXP)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_sob(in_sob), .in_eob(in_eob),
        .out_valid(out_valid), .out_sys(out_sys), .out_par(out_par),
        .out_tail(out_tail), .out_last(out_last), .out_err(out_err));

    always @(negedge clk) begin
        if (rst_n && out_valid && cap_n < 256) begin
            cap[cap_n] = {out_sys, out_par, out_tail, out_last, out_err};
            cap_n = cap_n + 1;
        end
    end

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] want);
        n_checks++;
        if (got !== want) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, got, want);
        end
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    endtask

    // reference step written from R3, R4, R6
    task automatic ref_step(input logic [1:0] mode, input logic [2:0] s, input logic a, input logic b,
                            input logic flush, output logic [2:0] ns, output logic sy,
                            output logic q0, output logic q1);
        logic f, u, w;
        if (mode == 2'd3) begin
            w  = a ^ b ^ s[0] ^ s[2];
            ns = {s[1] ^ b, s[0] ^ b, w};
            sy = a;
            q0 = w ^ s[1] ^ s[2];
            q1 = w ^ s[2];
        end else begin
            f  = s[1] ^ s[2];
            u  = flush ? f : a;
            w  = u ^ f;
            ns = {s[1], s[0], w};
            sy = u;
            q0 = w ^ s[0] ^ s[2];
            q1 = (mode == 2'd2) ? (w ^ s[0] ^ s[1] ^ s[2]) : 1'b0;
        end
    endtask

    task automatic build_expect(input logic [1:0] mode, input int len, input logic [127:0] d);
        logic [2:0] s, ns, sel;
        logic sy, q0, q1;
        exp_n = 0;
        if (mode != 2'd3) begin
            s = 3'd0;
            for (int k = 0; k < len; k++) begin
                ref_step(mode, s, d[k % 128], 1'b0, 1'b0, ns, sy, q0, q1);
                expv[exp_n] = {1'b0, sy, q1, q0, 3'b000};
                exp_n++;
                s = ns;
            end
            for (int k = 0; k < 3; k++) begin
                ref_step(mode, s, 1'b0, 1'b0, 1'b1, ns, sy, q0, q1);
                expv[exp_n] = {1'b0, sy, q1, q0, 1'b1, (k == 2), 1'b0};
                exp_n++;
                s = ns;
            end
        end else if (len > MAXP || (len % 7) == 0) begin
            expv[0] = 7'b0000011;
            exp_n = 1;
        end else begin
            sel = 3'd0;
            for (int c = 0; c < 8; c++) begin
                s = 3'(c);
                for (int k = 0; k < len; k++) begin
                    ref_step(mode, s, d[(2*k) % 128], d[(2*k+1) % 128], 1'b0, ns, sy, q0, q1);
                    s = ns;
                end
                if (s == 3'(c)) sel = 3'(c);
            end
            s = sel;
            for (int k = 0; k < len; k++) begin
                ref_step(mode, s, d[(2*k) % 128], d[(2*k+1) % 128], 1'b0, ns, sy, q0, q1);
                expv[exp_n] = {d[(2*k+1) % 128], d[(2*k) % 128], q1, q0, 1'b0, (k == len - 1), 1'b0};
                exp_n++;
                s = ns;
            end
        end
    endtask

    // drive one block; stall=1 inserts idle gaps; chg=1 flips cfg_mode after the first beat
    task automatic send_block(input string req, input logic [1:0] mode, input int len,
                              input logic [127:0] d, input logic stall, input logic chg);
        build_expect(mode, len, d);
        cap_n = 0;
        @(negedge clk);
        cfg_mode = mode;
        for (int k = 0; k < len; k++) begin
            if (stall && (k % 3) == 2) begin
                in_valid = 1'b0;
                @(negedge clk);
            end
            in_valid = 1'b1;
            in_sob   = (k == 0);
            in_eob   = (k == len - 1);
            in_data  = (mode == 2'd3) ? {d[(2*k+1) % 128], d[(2*k) % 128]} : {1'b0, d[k % 128]};
            while (!in_ready) @(negedge clk);
            @(negedge clk);
            if (chg && k == 0) cfg_mode = ~mode;
        end
        in_valid = 1'b0;
        in_sob   = 1'b0;
        in_eob   = 1'b0;
        if (exp_n > 1) check({req, " in_ready low after end of block"}, 32'(in_ready), 32'd0);
        for (int t = 0; t < 300; t++) begin
            if (cap_n > 0 && cap[cap_n-1][1]) break;
            @(negedge clk);
        end
        repeat (3) @(negedge clk);
        check({req, " beat count"}, 32'(cap_n), 32'(exp_n));
        for (int k = 0; k < exp_n; k++) begin
            check(req, 32'(cap[k]), 32'(expv[k]));
        end
        cfg_mode = mode;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 out_valid in reset", 32'(out_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 out_valid after reset", 32'(out_valid), 32'd0);
        check("R1 in_ready after reset", 32'(in_ready), 32'd1);

        // table walk: R3 R4 R5 R6 R7 R8
        for (int i = 0; i < NV; i++) begin
            case (T_MODE[i])
                2'd2:    send_block("R4 rate-1/5 block", T_MODE[i], T_LEN[i], T_DATA[i], i[0], 1'b0);
                2'd3:    send_block((T_LEN[i] % 7 == 0) ? "R8 length mod 7" : "R6 R7 duo-binary block",
                                    T_MODE[i], T_LEN[i], T_DATA[i], i[0], 1'b0);
                default: send_block("R3 R5 binary block", T_MODE[i], T_LEN[i], T_DATA[i], i[0], 1'b0);
            endcase
        end

        // R2: cfg_mode changed mid-block must not alter output
        send_block("R2 binary with mode change", 2'd1, 10, 128'h2C9, 1'b0, 1'b1);
        send_block("R2 duo with mode change", 2'd3, 9, 128'h3A7C5, 1'b0, 1'b1);

        // R9: duo block longer than buffer
        send_block("R9 overflow", 2'd3, MAXP + 1, 128'hF0E1_D2C3_B4A5_9687_7869_5A4B_3C2D_1E0F, 1'b0, 1'b0);

        // R10: beats without start flag while idle
        cap_n = 0;
        @(negedge clk);
        for (int k = 0; k < 4; k++) begin
            in_valid = 1'b1;
            in_data  = 2'(k);
            in_eob   = (k == 3);
            @(negedge clk);
        end
        in_valid = 1'b0;
        in_eob   = 1'b0;
        repeat (4) @(negedge clk);
        check("R10 no output for unframed beats", 32'(cap_n), 32'd0);
        check("R10 still idle", 32'(in_ready), 32'd1);

        // R5 after idle junk: state starts from zero again
        send_block("R5 binary after junk", 2'd0, 3, 128'h6, 1'b0, 1'b0);

        finish_run();
    end
endmodule